// File: doc/BRIEF.md
# DDR Mode Register Load Monitor

This block sits on the memory side of a DDR SDRAM command bus and tracks every load of the two mode registers. A load with both bank-address bits low writes the base register. A load with only the low bank-address bit set writes the extended register. For base-register loads, the upper address field is sorted into one of three classes: normal operation, DLL reset, or reserved. The programmed burst and latency fields are exposed as plain status pins.

From the extended register the block follows the DLL on/off state and the output drive selection. Each time the DLL goes from off to on, a lockout counter starts counting cycles with CKE high. A READ that arrives before the lockout has run out is recorded as a violation. Leaving self refresh turns the DLL on and restarts the lockout.

Three sticky violation flags report protocol errors: a reserved mode pattern, a load while the array is busy, and an early READ. They stay set until the clear pin is pulsed. The block observes the bus only, so it has no stream interface and applies no back-pressure. All of its pins are plain control and status.

Top module: `ddr_mrs_monitor`

## Requirements
- R1: A command is taken only on a rising edge with `cke` high and `cs_n` low. `{ras_n,cas_n,we_n}=000` is a register load and `101` is a READ. A load with `ba=2'b00` (`ba[0]` is BA0) goes to the base register and a load with `ba=2'b01` goes to the extended register. A load with `ba[1]=1` and every other command change nothing and set no flag.
- R2: A base load with `addr[12:7]==0` takes class normal. The next cycle shows `op_class=0`, `burst_len=addr[2:0]`, `burst_interleave=addr[3]` and `cas_lat=addr[6:4]`.
- R3: A base load with `addr[12:7]==6'b000010` (only bit 8 set) loads the same fields and shows `op_class=1`. It raises `dll_reset_pulse` for exactly the one following cycle.
- R4: A base load with any other `addr[12:7]` pattern leaves `burst_len`, `burst_interleave` and `cas_lat` unchanged, shows `op_class=2` and sets `flag_reserved`.
- R5: An extended load sets the DLL off when `addr[0]=1` and on when `addr[0]=0`, and selects reduced drive when `addr[1]=1`. Both settings hold until the next extended load or reset.
- R6: A base or extended load while `bank_open` or `burst_busy` is high sets `flag_illegal_load`. It changes no register field and leaves `op_class` unchanged.
- R7: When the DLL turns from off to on, the lockout restarts. `read_ready` rises once LOCK_CYCLES (default 200) cycles with `cke` high have followed that load. A READ while the DLL is on and `read_ready` is low sets `flag_read_early`. A READ with the DLL off, or with `read_ready` high, sets nothing. An extended load that keeps an already running DLL on does not restart the lockout.
- R8: Cycles with `cke` low pause the lockout count without clearing it.
- R9: A `sr_exit` pulse turns the DLL on, keeps the drive selection, and restarts the lockout, even when the lockout had already run out.
- R10: After reset, all fields are zero, `op_class=0`, the DLL is off, drive is normal, `read_ready` is low and all flags are clear.
- R11: Flags are sticky until `flag_clr` is sampled high. A flag event in the same cycle as `flag_clr` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable of the memory bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address, bit 0 is BA0 |
| addr | input | 13 | Address bus, carries the register value on a load |
| bank_open | input | 1 | High while any bank is open |
| burst_busy | input | 1 | High while a burst is running |
| sr_exit | input | 1 | One-cycle pulse on self-refresh exit |
| flag_clr | input | 1 | Clears the sticky flags |
| burst_len | output | 3 | Programmed burst length code |
| burst_interleave | output | 1 | Programmed burst type |
| cas_lat | output | 3 | Programmed CAS latency code |
| op_class | output | 2 | Class of the last accepted base load: 0 normal, 1 DLL reset, 2 reserved |
| dll_reset_pulse | output | 1 | One-cycle pulse after a DLL-reset load |
| dll_enabled | output | 1 | DLL currently on |
| drive_reduced | output | 1 | Reduced output drive selected |
| read_ready | output | 1 | DLL on and lockout finished |
| flag_reserved | output | 1 | Sticky: reserved base pattern seen |
| flag_illegal_load | output | 1 | Sticky: register load while busy |
| flag_read_early | output | 1 | Sticky: READ during lockout |

## Verification
Every register field, `op_class`, `dll_reset_pulse` and each flag is updated on the rising edge that samples the command. They are due one cycle after the command is driven. The bench drives on the falling edge and checks on the next falling edge. `read_ready` is due after exactly LOCK_CYCLES `cke`-high edges following the enabling edge. The bench counts those edges itself and checks both the edge before and the edge on which the count completes. The early-READ case is checked with the READ placed on the last lockout edge. The pause case inserts `cke`-low cycles and expects the deadline to shift by exactly that many cycles.

// File: rtl/ddr_mrs_pkg.sv
package ddr_mrs_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE     = 3'd0,
    CMD_LD_BASE  = 3'd1,
    CMD_LD_EXT   = 3'd2,
    CMD_LD_SKIP  = 3'd3,
    CMD_READ     = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_NORMAL   = 2'd0,
    CLS_DLL_RST  = 2'd1,
    CLS_RESERVED = 2'd2
  } op_class_e;

  typedef struct packed {
    logic drive_red;
    logic dll_off;
  } ext_reg_t;
endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_mrs_pkg::*;
(
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  output cmd_e       cmd
);
  always_comb begin
    cmd = CMD_IDLE;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000: begin
          case (ba)
            2'b00:   cmd = CMD_LD_BASE;
            2'b01:   cmd = CMD_LD_EXT;
            default: cmd = CMD_LD_SKIP;
          endcase
        end
        3'b101:  cmd = CMD_READ;
        default: cmd = CMD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_mode_regs.sv
module ddr_mode_regs
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LOW_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              blocked,
  input  logic              sr_exit,
  output logic [LOW_W-1:0]  base_q,
  output op_class_e         cls_q,
  output ext_reg_t          ext_q,
  output logic              rst_pulse,
  output logic              hit_reserved,
  output logic              hit_illegal,
  output logic              dll_on_event
);
  localparam int UP_W = ADDR_W - LOW_W;
  localparam logic [UP_W-1:0] DLLRST_PAT = UP_W'(2);

  logic [UP_W-1:0] upper;
  op_class_e       cls_now;
  logic            is_load;
  logic            base_ok;
  logic            ext_ok;

  assign upper   = addr[ADDR_W-1:LOW_W];
  assign is_load = (cmd == CMD_LD_BASE) || (cmd == CMD_LD_EXT);
  assign base_ok = (cmd == CMD_LD_BASE) && !blocked;
  assign ext_ok  = (cmd == CMD_LD_EXT) && !blocked;

  always_comb begin
    if (upper == '0)             cls_now = CLS_NORMAL;
    else if (upper == DLLRST_PAT) cls_now = CLS_DLL_RST;
    else                          cls_now = CLS_RESERVED;
  end

  assign hit_illegal  = is_load && blocked;
  assign hit_reserved = base_ok && (cls_now == CLS_RESERVED);
  assign dll_on_event = sr_exit || (ext_ok && !addr[0] && ext_q.dll_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      cls_q     <= CLS_NORMAL;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= base_ok && (cls_now == CLS_DLL_RST);
      if (base_ok) begin
        cls_q <= cls_now;
        if (cls_now != CLS_RESERVED) base_q <= addr[LOW_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '{drive_red: 1'b0, dll_off: 1'b1};
    end else begin
      if (ext_ok) ext_q <= '{drive_red: addr[1], dll_off: addr[0]};
      if (sr_exit) ext_q.dll_off <= 1'b0;
    end
  end

  p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_illegal && !sr_exit |=> $stable(base_q) && $stable(ext_q) && $stable(cls_q));

  p_reserved_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_reserved |=> $stable(base_q) && (cls_q == CLS_RESERVED));

  p_pulse_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (cls_q == CLS_DLL_RST));

  p_srx_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit |=> !ext_q.dll_off);
endmodule

// File: rtl/ddr_dll_lockout.sv
module ddr_dll_lockout #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic dll_en,
  input  logic restart,
  output logic ready
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (restart)               cnt <= '0;
    else if (!dll_en)               cnt <= '0;
    else if (cke && (cnt != LIMIT)) cnt <= cnt + 1'b1;
  end

  assign ready = dll_en && (cnt == LIMIT);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT);

  p_restart_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !ready);

  p_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en && !cke && !restart |=> $stable(cnt));
endmodule

// File: rtl/ddr_viol_flags.sv
module ddr_viol_flags #(
  parameter int N_FLAGS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FLAGS-1:0] set,
  input  logic               clr,
  output logic [N_FLAGS-1:0] flg
);
  for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flg[gi] <= 1'b0;
      else if (set[gi]) flg[gi] <= 1'b1;
      else if (clr)     flg[gi] <= 1'b0;
    end

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flg[gi] && !clr |=> flg[gi]);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set[gi] |=> flg[gi]);
  end
endmodule

// File: rtl/ddr_mrs_monitor.sv
module ddr_mrs_monitor
  import ddr_mrs_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank_open,
  input  logic              burst_busy,
  input  logic              sr_exit,
  input  logic              flag_clr,
  output logic [2:0]        burst_len,
  output logic              burst_interleave,
  output logic [2:0]        cas_lat,
  output logic [1:0]        op_class,
  output logic              dll_reset_pulse,
  output logic              dll_enabled,
  output logic              drive_reduced,
  output logic              read_ready,
  output logic              flag_reserved,
  output logic              flag_illegal_load,
  output logic              flag_read_early
);
  localparam int LOW_W = 7;

  cmd_e             cmd;
  logic [LOW_W-1:0] base_q;
  op_class_e        cls_q;
  ext_reg_t         ext_q;
  logic             hit_reserved;
  logic             hit_illegal;
  logic             dll_on_event;
  logic             hit_early;
  logic [2:0]       flg;

  ddr_cmd_decode u_dec (
    .cke   (cke),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .cmd   (cmd)
  );

  ddr_mode_regs #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd          (cmd),
    .addr         (addr),
    .blocked      (bank_open || burst_busy),
    .sr_exit      (sr_exit),
    .base_q       (base_q),
    .cls_q        (cls_q),
    .ext_q        (ext_q),
    .rst_pulse    (dll_reset_pulse),
    .hit_reserved (hit_reserved),
    .hit_illegal  (hit_illegal),
    .dll_on_event (dll_on_event)
  );

  assign dll_enabled   = !ext_q.dll_off;
  assign drive_reduced = ext_q.drive_red;

  ddr_dll_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .dll_en  (dll_enabled),
    .restart (dll_on_event),
    .ready   (read_ready)
  );

  assign hit_early = (cmd == CMD_READ) && dll_enabled && !read_ready;

  ddr_viol_flags #(.N_FLAGS(3)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   ({hit_early, hit_illegal, hit_reserved}),
    .clr   (flag_clr),
    .flg   (flg)
  );

  assign flag_reserved     = flg[0];
  assign flag_illegal_load = flg[1];
  assign flag_read_early   = flg[2];

  assign burst_len        = base_q[2:0];
  assign burst_interleave = base_q[3];
  assign cas_lat          = base_q[6:4];
  assign op_class         = cls_q;

  p_ready_needs_dll_r7: assert property (@(posedge clk) disable iff (!rst_n)
    read_ready |-> dll_enabled);

  p_early_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_READ) && dll_enabled && !read_ready |=> flag_read_early);
endmodule

// File: tb/ddr_mrs_monitor_tb.sv
`timescale 1ns/1ps
module ddr_mrs_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic        bank_open = 1'b0, burst_busy = 1'b0, sr_exit = 1'b0, flag_clr = 1'b0;
  logic [2:0]  burst_len, cas_lat;
  logic        burst_interleave;
  logic [1:0]  op_class;
  logic        dll_reset_pulse, dll_enabled, drive_reduced, read_ready;
  logic        flag_reserved, flag_illegal_load, flag_read_early;

  int checks = 0;
  int failures = 0;
  logic [6:0] exp_base;
  int         exp_cls;
  logic       exp_res;

  always #4 clk = ~clk;

  ddr_mrs_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .bank_open(bank_open),
    .burst_busy(burst_busy), .sr_exit(sr_exit), .flag_clr(flag_clr),
    .burst_len(burst_len), .burst_interleave(burst_interleave), .cas_lat(cas_lat),
    .op_class(op_class), .dll_reset_pulse(dll_reset_pulse), .dll_enabled(dll_enabled),
    .drive_reduced(drive_reduced), .read_ready(read_ready),
    .flag_reserved(flag_reserved), .flag_illegal_load(flag_illegal_load),
    .flag_read_early(flag_read_early)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic load(input logic [1:0] b, input logic [12:0] a);
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; ba = b; addr = a;
    step(1);
    idle_bus();
  endtask

  task automatic rd();
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b0; we_n = 1'b1;
    step(1);
    idle_bus();
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic chk_fields(input string req);
    chk({req, " burst_len"}, burst_len, exp_base[2:0]);
    chk({req, " interleave"}, burst_interleave, exp_base[3]);
    chk({req, " cas_lat"}, cas_lat, exp_base[6:4]);
    chk({req, " op_class"}, op_class, exp_cls);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_base = '0; exp_cls = 0; exp_res = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk_fields("R10");
    chk("R10 dll_enabled", dll_enabled, 0);
    chk("R10 drive_reduced", drive_reduced, 0);
    chk("R10 read_ready", read_ready, 0);
    chk("R10 flags", {flag_reserved, flag_illegal_load, flag_read_early}, 0);
    chk("R10 dll_reset_pulse", dll_reset_pulse, 0);

    // R2 R3 R4: sweep every upper pattern
    for (int u = 0; u < 64; u++) begin
      logic [6:0] low;
      low = 7'((u * 37 + 5) & 127);
      load(2'b00, {6'(u), low});
      if (u == 0) begin exp_cls = 0; exp_base = low; end
      else if (u == 2) begin exp_cls = 1; exp_base = low; end
      else begin exp_cls = 2; exp_res = 1'b1; end
      chk_fields(u == 0 ? "R2" : (u == 2 ? "R3" : "R4"));
      chk("R4 flag_reserved", flag_reserved, exp_res);
      chk("R3 pulse", dll_reset_pulse, (u == 2) ? 1 : 0);
      if (u == 2) begin
        step(1);
        chk("R3 pulse single", dll_reset_pulse, 0);
      end
    end
    load(2'b00, 13'h05A);
    exp_base = 7'h5A; exp_cls = 0;
    chk_fields("R2 final");
    clear_flags();
    chk("R11 clr", flag_reserved, 0);

    // R1: foreign bank selects, non-load commands, CKE low
    load(2'b10, 13'h1FFF);
    chk_fields("R1 ba10");
    load(2'b11, 13'h0013);
    chk_fields("R1 ba11");
    chk("R1 ext untouched", drive_reduced, 0);
    cke = 1'b0; load(2'b00, 13'h0033); cke = 1'b1;
    chk_fields("R1 cke low");
    cs_n = 1'b0; ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b1; addr = 13'h0044; ba = 2'b00;
    step(1); idle_bus();
    chk_fields("R1 refresh");
    chk("R1 no flags", {flag_reserved, flag_illegal_load, flag_read_early}, 0);

    // R5: extended register sweep
    for (int e = 0; e < 4; e++) begin
      load(2'b01, 13'(e));
      chk("R5 dll", dll_enabled, (e & 1) ? 0 : 1);
      chk("R5 drive", drive_reduced, (e >> 1) & 1);
      step(5);
      chk("R5 persist", drive_reduced, (e >> 1) & 1);
    end
    chk_fields("R5 base intact");

    // R6: loads while busy
    for (int b = 1; b < 4; b++) begin
      bank_open = b[0]; burst_busy = b[1];
      load(2'b00, 13'h0100 | 13'h0011);
      chk_fields("R6 base");
      load(2'b01, 13'h0000);
      chk("R6 ext dll", dll_enabled, 0);
      chk("R6 ext drive", drive_reduced, 1);
      chk("R6 flag", flag_illegal_load, 1);
      chk("R6 no reserved", flag_reserved, 0);
      bank_open = 1'b0; burst_busy = 1'b0;
      clear_flags();
      chk("R6 clr", flag_illegal_load, 0);
    end

    // R7: lockout, early READ
    load(2'b01, 13'h0000);
    chk("R7 enabled", dll_enabled, 1);
    step(199);
    chk("R7 not ready 199", read_ready, 0);
    rd();
    chk("R7 early flag", flag_read_early, 1);
    chk("R7 ready 200", read_ready, 1);
    clear_flags();
    rd();
    chk("R7 read ok", flag_read_early, 0);
    load(2'b01, 13'h0000);
    chk("R7 no restart when on", read_ready, 1);
    load(2'b01, 13'h0001);
    chk("R7 off not ready", read_ready, 0);
    rd();
    chk("R7 read with dll off", flag_read_early, 0);
    load(2'b01, 13'h0000);
    step(199);
    chk("R7 restart 199", read_ready, 0);
    step(1);
    chk("R7 restart 200", read_ready, 1);
    rd();
    chk("R7 read after lockout", flag_read_early, 0);

    // R8: CKE low pauses
    load(2'b01, 13'h0001);
    load(2'b01, 13'h0000);
    step(100);
    cke = 1'b0; step(30); cke = 1'b1;
    chk("R8 paused", read_ready, 0);
    step(99);
    chk("R8 199", read_ready, 0);
    step(1);
    chk("R8 200", read_ready, 1);

    // R9: self-refresh exit
    load(2'b01, 13'h0003);
    chk("R9 off", dll_enabled, 0);
    sr_exit = 1'b1; step(1); sr_exit = 1'b0;
    chk("R9 enabled", dll_enabled, 1);
    chk("R9 drive kept", drive_reduced, 1);
    chk("R9 not ready", read_ready, 0);
    step(199);
    chk("R9 199", read_ready, 0);
    step(1);
    chk("R9 200", read_ready, 1);
    sr_exit = 1'b1; step(1); sr_exit = 1'b0;
    chk("R9 restart", read_ready, 0);

    // R11: set wins over clear
    clear_flags();
    flag_clr = 1'b1;
    load(2'b00, 13'h1000);
    flag_clr = 1'b0;
    chk("R11 set wins", flag_reserved, 1);
    step(3);
    chk("R11 sticky", flag_reserved, 1);
    clear_flags();
    chk("R11 cleared", flag_reserved, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule